// File: doc/BRIEF.md
# Serial Register Command Slave

This block is a serial-peripheral slave that accepts fixed 20-bit frames from a master and serves a small, directly addressed register file. The master frames each transaction with an active-low select, clocks data in on the serial clock and reads the slave's answer on a separate return line. A frame has a 4-bit command nibble, an 8-bit address and 8 data bits. Two nibble values form the short register group: one stores a byte and the other fetches a byte. Every other nibble belongs to a wider command set that a separate sequencer handles, so those frames are handed over whole.

The slave runs entirely on the system clock. It treats select, serial clock and serial data as synchronous inputs and finds their edges by comparing each input with its value one cycle earlier. A read produces a reply frame that carries the read code, the address and the stored byte. That reply goes out on the return line during the next frame the master opens. When nothing is pending, the slave sends zeros.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is taken MSB first: one data bit is sampled on each rising serial-clock edge while select is low, and the first 4 bits are the command nibble.
- R2: A committed frame with nibble 0x8 stores bits [7:0] into the register at address bits [15:8]. The store happens when select returns high, and every address from 0x00 to 0xFF is reachable.
- R3: A committed frame with nibble 0x9 fetches the register at address bits [15:8] and ignores its own bits [7:0]. The next frame then shifts out {0x9, address, byte} on the return line, MSB first.
- R4: A write frame produces no reply: the frame after a write shifts out all zeros, unless a read reply was already pending.
- R5: A frame is committed only if exactly 20 rising serial-clock edges arrived while select was low. Shorter and longer frames store nothing, produce no reply and are not forwarded.
- R6: The return line changes only after a falling serial-clock edge or at the start of a frame. It is zero while select is high and zero when no reply is pending. A pending reply is delivered in exactly one frame.
- R7: A committed frame whose nibble is neither 0x8 nor 0x9 raises the forward valid output for one cycle, with the whole 20-bit frame on the forward data output. It leaves the register file untouched.
- R8: After reset all registers read as zero, the return line is low and the forward valid output is low.
- R9: The reply carries the byte as it stood when the read was committed. A write carried in the frame that shifts the reply out does not alter that reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiSelN | input | 1 | Active-low frame select from the master |
| spiSck | input | 1 | Serial clock from the master |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial reply data to the master |
| fwdValid | output | 1 | One-cycle strobe for a frame handed to the sequencer |
| fwdData | output | 20 | Forwarded frame, valid while fwdValid is high |

## Verification
The bench builds the block with its default widths: a 4-bit command, an 8-bit address and 8-bit data. This makes the frame 20 bits and the register file 256 entries deep, so the lowest and highest addresses can both be exercised. Each serial-clock phase lasts two system clocks. This leaves room between edges to tell the cycle in which the return line moves apart from the cycle in which the master samples it. Frames of 19 and 21 bits are sent to exercise the length rule on write, read and forwarded nibbles.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Strobes passed from the control half to the datapath, one cycle each
  typedef struct packed {
    logic frameStart;  // select just went low
    logic frameEnd;    // select just went high
    logic shiftIn;     // rising serial clock inside a frame
    logic shiftOut;    // falling serial clock inside a frame
    logic commitWr;    // complete frame, store command
    logic commitRd;    // complete frame, fetch command
    logic commitFwd;   // complete frame, other command group
  } strobes_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W = 20,
  parameter int CMD_W   = 4,
  parameter logic [CMD_W-1:0] WR_CODE = 4'h8,
  parameter logic [CMD_W-1:0] RD_CODE = 4'h9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selN,
  input  logic             sck,
  input  logic [CMD_W-1:0] cmd,
  output strobes_t         strb
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic             sckQ;
  logic             selQ;
  logic [CNT_W-1:0] bitCnt;
  logic             inFrame;
  logic             lenOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckQ <= 1'b0;
      selQ <= 1'b1;
    end else begin
      sckQ <= sck;
      selQ <= selN;
    end
  end

  assign inFrame = !selN && !selQ;

  always_comb begin
    strb            = '0;
    strb.frameStart = selQ && !selN;
    strb.frameEnd   = !selQ && selN;
    strb.shiftIn    = inFrame && sck && !sckQ;
    strb.shiftOut   = inFrame && !sck && sckQ;
    lenOk           = (bitCnt == CNT_FULL);
    strb.commitWr   = strb.frameEnd && lenOk && (cmd == WR_CODE);
    strb.commitRd   = strb.frameEnd && lenOk && (cmd == RD_CODE);
    strb.commitFwd  = strb.frameEnd && lenOk && (cmd != WR_CODE) && (cmd != RD_CODE);
  end

  // Counts clock edges up to one past a full frame, then holds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
    end else if (strb.frameStart) begin
      bitCnt <= '0;
    end else if (strb.shiftIn && bitCnt != CNT_OVER) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [CMD_W-1:0] RD_CODE = 4'h9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mosi,
  input  strobes_t                         strb,
  output logic [CMD_W-1:0]                 cmd,
  output logic                             txMsb,
  output logic                             replyPending,
  output logic                             fwdValid,
  output logic [CMD_W+ADDR_W+DATA_W-1:0]   fwdData
);

  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [FRAME_W-1:0] rxShift;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] replyWord;
  logic [DATA_W-1:0]  regFile [DEPTH];
  logic [ADDR_W-1:0]  rxAddr;
  logic [DATA_W-1:0]  rxData;

  assign cmd    = rxShift[FRAME_W-1 -: CMD_W];
  assign rxAddr = rxShift[DATA_W +: ADDR_W];
  assign rxData = rxShift[DATA_W-1:0];
  assign txMsb  = txShift[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[FRAME_W-2:0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (strb.commitWr) begin
      regFile[rxAddr] <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replyWord    <= '0;
      replyPending <= 1'b0;
    end else if (strb.commitRd) begin
      replyWord    <= {RD_CODE, rxAddr, regFile[rxAddr]};
      replyPending <= 1'b1;
    end else if (strb.frameStart) begin
      replyPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
    end else if (strb.frameStart) begin
      txShift <= replyPending ? replyWord : '0;
    end else if (strb.frameEnd) begin
      txShift <= '0;
    end else if (strb.shiftOut) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwdValid <= 1'b0;
      fwdData  <= '0;
    end else begin
      fwdValid <= strb.commitFwd;
      if (strb.commitFwd) fwdData <= rxShift;
    end
  end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [CMD_W-1:0] WR_CODE = 4'h8,
  parameter logic [CMD_W-1:0] RD_CODE = 4'h9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           spiSelN,
  input  logic                           spiSck,
  input  logic                           spiMosi,
  output logic                           spiMiso,
  output logic                           fwdValid,
  output logic [CMD_W+ADDR_W+DATA_W-1:0] fwdData
);

  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;

  strobes_t         strb;
  logic [CMD_W-1:0] cmd;
  logic             txMsb;
  logic             replyPending;

  spi_reg_ctrl #(
    .FRAME_W(FRAME_W), .CMD_W(CMD_W), .WR_CODE(WR_CODE), .RD_CODE(RD_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .selN(spiSelN), .sck(spiSck), .cmd(cmd), .strb(strb)
  );

  spi_reg_dp #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CODE(RD_CODE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .mosi(spiMosi), .strb(strb), .cmd(cmd),
    .txMsb(txMsb), .replyPending(replyPending),
    .fwdValid(fwdValid), .fwdData(fwdData)
  );

  assign spiMiso = !spiSelN && txMsb;

endmodule

// File: rtl/spi_reg_chk.sv
module spi_reg_chk
  import spi_reg_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ssn,
  input logic     miso,
  input logic     fwdValid,
  input logic     replyPending,
  input strobes_t strb
);

  // R1: bits are taken only while the frame is open
  p_shift_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftIn |-> (!ssn && $past(!ssn)));

  // R5: commits happen only when select closes the frame
  p_commit_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commitWr || strb.commitRd || strb.commitFwd) |-> (strb.frameEnd && ssn));

  // R5: at most one kind of commit per frame
  p_commit_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.commitWr, strb.commitRd, strb.commitFwd}));

  // R6: return line moves only after a falling clock or at frame start
  p_miso_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ssn && $past(!ssn) && !$stable(miso)) |-> $past(strb.shiftOut || strb.frameStart));

  // R6: nothing is driven while deselected
  p_miso_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ssn |-> !miso);

  // R3: a pending reply starts with the read code MSB
  p_reply_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.frameStart && replyPending) |=> (ssn || miso));

  // R7: forward strobe is a single cycle following deselect
  p_fwd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |=> !fwdValid);

  p_fwd_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> $past(ssn));

endmodule

bind spi_reg_slave spi_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ssn(spiSelN), .miso(spiMiso),
  .fwdValid(fwdValid), .replyPending(replyPending), .strb(strb)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic selN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic fwdValid;
  logic [FW-1:0] fwdData;

  int total = 0;
  int bad = 0;
  int fwdSeen = 0;
  logic [FW-1:0] fwdLast = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spiSelN(selN), .spiSck(sck), .spiMosi(mosi),
    .spiMiso(miso), .fwdValid(fwdValid), .fwdData(fwdData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mem [256];
  bit  bitQ [$];
  bit  txQ [$];
  bit  pend = 0;
  logic [FW-1:0] pendWord = '0;
  bit  prevSck = 0, prevSel = 1;
  bit  expFwd = 0;
  logic [FW-1:0] expFwdData = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      bitQ.delete(); txQ.delete();
      pend = 0; prevSck = 0; prevSel = 1; expFwd = 0;
    end else begin
      expFwd = 0;
      if (prevSel && !selN) begin
        bitQ.delete(); txQ.delete();
        if (pend) for (int i = FW-1; i >= 0; i--) txQ.push_back(pendWord[i]);
        pend = 0;
      end else if (!selN && !prevSel) begin
        if (sck && !prevSck) bitQ.push_back(mosi);
        if (!sck && prevSck && txQ.size() > 0) void'(txQ.pop_front());
      end
      if (!prevSel && selN) begin
        txQ.delete();
        if (bitQ.size() == FW) begin
          logic [FW-1:0] w;
          w = '0;
          foreach (bitQ[i]) w = {w[FW-2:0], bitQ[i]};
          if (w[19:16] == 4'h8) mem[w[15:8]] = int'(w[7:0]);
          else if (w[19:16] == 4'h9) begin
            pend = 1; pendWord = {4'h9, w[15:8], 8'(mem[w[15:8]])};
          end else begin
            expFwd = 1; expFwdData = w;
          end
        end
      end
      prevSck = sck; prevSel = selN;
    end
    #(CLK_PERIOD/4);
    begin
      bit em;
      em = (!selN && txQ.size() > 0) ? txQ[0] : 1'b0;
      chk(miso === em, "R6 miso", 32'(miso), 32'(em));
      chk(fwdValid === expFwd, "R7 fwdValid", 32'(fwdValid), 32'(expFwd));
      if (expFwd) chk(fwdData === expFwdData, "R7 fwdData", 32'(fwdData), 32'(expFwdData));
      if (fwdValid) begin fwdSeen++; fwdLast = fwdData; end
    end
  end

  // ---------------- master driver ----------------
  task automatic xfer(input logic [31:0] word, input int nbits, output logic [FW-1:0] got);
    got = '0;
    @(negedge clk); selN = 1'b0; sck = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = nbits-1; i >= 0; i--) begin
      mosi = word[i]; sck = 1'b0;
      repeat (2) @(negedge clk);
      got = {got[FW-2:0], miso};
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    repeat (2) @(negedge clk);
    selN = 1'b1; mosi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] g;
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miso === 1'b0, "R8 miso after reset", 32'(miso), 0);
    chk(fwdValid === 1'b0, "R8 fwdValid after reset", 32'(fwdValid), 0);

    // R8/R1/R3: fresh register reads zero, reply echoes code and address
    xfer(32'h93C00, FW, g);
    xfer(32'h93C00, FW, g);
    chk(g === 20'h93C00, "R8 R1 reset register reply", 32'(g), 32'h93C00);

    // R2/R3/R4/R9
    xfer(32'h81EC3, FW, g);
    chk(g === 20'h93C00, "R3 reply in next frame", 32'(g), 32'h93C00);
    xfer(32'h91EFF, FW, g);
    chk(g === 20'h00000, "R4 no reply after write", 32'(g), 0);
    xfer(32'h81E55, FW, g);
    chk(g === 20'h91EC3, "R9 R3 reply held, data bits ignored", 32'(g), 32'h91EC3);
    xfer(32'h91E00, FW, g);
    chk(g === 20'h00000, "R6 reply delivered once", 32'(g), 0);
    xfer(32'h8FF01, FW, g);
    chk(g === 20'h91E55, "R2 overwrite visible", 32'(g), 32'h91E55);

    // R2 address boundaries
    xfer(32'h80077, FW, g);
    xfer(32'h900AA, FW, g);
    xfer(32'h9FF00, FW, g);
    chk(g === 20'h90077, "R2 address 0x00", 32'(g), 32'h90077);
    xfer(32'h80000, FW, g);
    chk(g === 20'h9FF01, "R2 address 0xFF", 32'(g), 32'h9FF01);

    // R5 wrong lengths
    f0 = fwdSeen;
    xfer(32'h840AA >> 1, FW-1, g);
    xfer((32'h840AA << 1) | 1, FW+1, g);
    xfer(32'h14082 >> 1, FW-1, g);
    xfer(32'h94000, FW, g);
    xfer(32'h94000, FW, g);
    chk(g === 20'h94000, "R5 short/long write discarded", 32'(g), 32'h94000);
    chk(fwdSeen == f0, "R5 short frame not forwarded", 32'(fwdSeen), 32'(f0));
    xfer(32'h94000 >> 1, FW-1, g);
    xfer(32'h80101, FW, g);
    chk(g === 20'h00000, "R5 short read gives no reply", 32'(g), 0);

    // R7 forwarding
    f0 = fwdSeen;
    xfer(32'h140AB, FW, g);
    chk(fwdSeen == f0 + 1, "R7 one forward strobe", 32'(fwdSeen), 32'(f0 + 1));
    chk(fwdLast === 20'h140AB, "R7 forwarded frame", 32'(fwdLast), 32'h140AB);
    xfer(32'hFFFFF, FW, g);
    chk(fwdLast === 20'hFFFFF, "R7 forwarded nibble F", 32'(fwdLast), 32'hFFFFF);
    xfer(32'h94000, FW, g);
    xfer(32'h94000, FW, g);
    chk(g === 20'h94000, "R7 forward leaves registers", 32'(g), 32'h94000);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule